// File: doc/BRIEF.md
# BCD Digit to Seven-Segment Decoder with Capture Latch

This block takes a 4-bit binary-coded-decimal digit and drives the seven segment lines of a single display digit. A capture control picks the source. While it is high, the segments track the incoming code. While it is low, they show the code held in an internal register. That register is loaded on every clock edge at which the control is high.

Two active-low overrides sit after the decoder. Lamp test lights every segment. Blanking darkens every segment and leaves the held code untouched. A build-time parameter sets the output polarity so the block can drive either a common-cathode display or a common-anode display. The polarity inversion is the last stage and also acts on the override patterns.

Top module: `bcd7_latch_decoder`

## Requirements
- R1: With capture high and no override active, `seg_o` bit 0..6 map to segments a..g; for a common-cathode build, digits 0..3 give 7'h3F, 7'h06, 7'h5B, 7'h4F.
- R2: Digits 4..9 give 7'h66, 7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F in the common-cathode build.
- R3: Input codes 10..15 give an all-dark display (7'h00 in the common-cathode build).
- R4: While `capture_i` is high, `seg_o` reflects `bcd_i` in the same cycle, with no clock delay.
- R5: While `capture_i` is low, `seg_o` shows the code sampled at the last rising edge with `capture_i` high, and changes on `bcd_i` have no effect.
- R6: `lamp_test_ni` low lights all seven segments, whatever the blanking, capture and digit inputs are.
- R7: `blank_ni` low with `lamp_test_ni` high turns all seven segments off.
- R8: Blanking does not alter the held code, so after blanking is released with capture still low, the held digit reappears.
- R9: With `COMMON_ANODE` = 1, every output bit is the inverse of the common-cathode value, and the lamp-test and blank patterns are inverted as well.
- R10: Reset (`rst_ni` low) clears the held code to 0, so with capture low after reset the display shows digit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bcd_i | input | 4 | BCD digit code |
| capture_i | input | 1 | High: follow input and load register; low: show held code |
| lamp_test_ni | input | 1 | Lamp test, active low, highest priority |
| blank_ni | input | 1 | Blanking, active low |
| seg_o | output | 7 | Segment lines, bit 0 = a through bit 6 = g |

## Verification
The hardest case is a held code that must survive an intervening blank while the input keeps moving. Only the output can show this, and the output is dark for the whole time the held code matters. The stimulus loads a digit, drops capture, and changes `bcd_i` to a different digit. It then asserts blanking for several clock edges and releases it with capture still low. The old digit must come back, which shows that neither the input changes nor the blank reached the register. Reset is then checked by holding capture low across reset and expecting digit 0.

// File: rtl/bcd7_pkg.sv
package bcd7_pkg;
  localparam int DIGIT_W = 4;
  localparam int SEG_N   = 7;
  localparam int MAX_DIGIT = 9;

  typedef logic [DIGIT_W-1:0] digit_t;
  typedef logic [SEG_N-1:0]   seg_t;

  localparam seg_t SEG_DARK = '0;
  localparam seg_t SEG_FULL = '1;
endpackage

// File: rtl/bcd7_hold.sv
module bcd7_hold
  import bcd7_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   capture_i,
  input  digit_t bcd_i,
  output digit_t src_o
);
  digit_t held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        held_q <= '0;
    else if (capture_i) held_q <= bcd_i;
  end

  // transparent while capturing, frozen otherwise
  assign src_o = capture_i ? bcd_i : held_q;
endmodule

// File: rtl/bcd7_decode.sv
module bcd7_decode
  import bcd7_pkg::*;
(
  input  digit_t digit_i,
  output seg_t   lit_o
);
  // bit order {g,f,e,d,c,b,a}, 1 = lit
  always_comb begin
    unique case (digit_i)
      4'd0:    lit_o = 7'b011_1111;
      4'd1:    lit_o = 7'b000_0110;
      4'd2:    lit_o = 7'b101_1011;
      4'd3:    lit_o = 7'b100_1111;
      4'd4:    lit_o = 7'b110_0110;
      4'd5:    lit_o = 7'b110_1101;
      4'd6:    lit_o = 7'b111_1101;
      4'd7:    lit_o = 7'b000_0111;
      4'd8:    lit_o = 7'b111_1111;
      4'd9:    lit_o = 7'b110_1111;
      default: lit_o = SEG_DARK;
    endcase
  end
endmodule

// File: rtl/bcd7_drive.sv
module bcd7_drive
  import bcd7_pkg::*;
#(
  parameter bit COMMON_ANODE = 1'b0
) (
  input  seg_t lit_i,
  input  logic lamp_test_ni,
  input  logic blank_ni,
  output seg_t seg_o
);
  seg_t lit_ovr;

  always_comb begin
    if (!lamp_test_ni)  lit_ovr = SEG_FULL;
    else if (!blank_ni) lit_ovr = SEG_DARK;
    else                lit_ovr = lit_i;
  end

  generate
    if (COMMON_ANODE) begin : g_ca
      assign seg_o = ~lit_ovr;
    end else begin : g_cc
      assign seg_o = lit_ovr;
    end
  endgenerate
endmodule

// File: rtl/bcd7_latch_decoder.sv
module bcd7_latch_decoder
  import bcd7_pkg::*;
#(
  parameter bit COMMON_ANODE = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [DIGIT_W-1:0]  bcd_i,
  input  logic                capture_i,
  input  logic                lamp_test_ni,
  input  logic                blank_ni,
  output logic [SEG_N-1:0]    seg_o
);
  localparam seg_t ON_ALL  = COMMON_ANODE ? SEG_DARK : SEG_FULL;
  localparam seg_t OFF_ALL = COMMON_ANODE ? SEG_FULL : SEG_DARK;

  digit_t src;
  seg_t   lit;

  bcd7_hold u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture_i),
    .bcd_i     (bcd_i),
    .src_o     (src)
  );

  bcd7_decode u_decode (
    .digit_i (src),
    .lit_o   (lit)
  );

  bcd7_drive #(.COMMON_ANODE(COMMON_ANODE)) u_drive (
    .lit_i        (lit),
    .lamp_test_ni (lamp_test_ni),
    .blank_ni     (blank_ni),
    .seg_o        (seg_o)
  );

  AST_LAMP_ALL_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lamp_test_ni |-> seg_o == ON_ALL); // R6

  AST_BLANK_ALL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lamp_test_ni && !blank_ni) |-> seg_o == OFF_ALL); // R7

  AST_BAD_CODE_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lamp_test_ni && blank_ni && capture_i && bcd_i > MAX_DIGIT) |-> seg_o == OFF_ALL); // R3

  AST_DIGIT_ONE_TWO_SEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lamp_test_ni && blank_ni && capture_i && bcd_i == 4'd1)
      |-> $countones(seg_o ^ OFF_ALL) == 2); // R1

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!capture_i && $past(!capture_i) && lamp_test_ni && blank_ni
     && $past(lamp_test_ni) && $past(blank_ni)) |-> $stable(seg_o)); // R5
endmodule

// File: tb/bcd7_latch_decoder_tb.sv
module bcd7_latch_decoder_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] bcd;
  logic       cap, lt_n, bl_n;
  logic [6:0] seg_cc, seg_ca;
  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  bcd7_latch_decoder #(.COMMON_ANODE(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bcd_i(bcd), .capture_i(cap),
    .lamp_test_ni(lt_n), .blank_ni(bl_n), .seg_o(seg_cc));

  bcd7_latch_decoder #(.COMMON_ANODE(1'b1)) u_dut_ca (
    .clk_i(clk), .rst_ni(rst_n), .bcd_i(bcd), .capture_i(cap),
    .lamp_test_ni(lt_n), .blank_ni(bl_n), .seg_o(seg_ca));

  function automatic logic [6:0] pat(input logic [3:0] d);
    case (d)
      4'd0: return 7'h3F; 4'd1: return 7'h06; 4'd2: return 7'h5B;
      4'd3: return 7'h4F; 4'd4: return 7'h66; 4'd5: return 7'h6D;
      4'd6: return 7'h7D; 4'd7: return 7'h07; 4'd8: return 7'h7F;
      4'd9: return 7'h6F; default: return 7'h00;
    endcase
  endfunction

  // compares both builds; exp is the common-cathode value
  task automatic chk(input string req, input logic [6:0] exp);
    n_cmp++;
    if (seg_cc !== exp) begin
      n_bad++;
      $display("FAIL %s cc: got %h exp %h", req, seg_cc, exp);
    end
    n_cmp++;
    if (seg_ca !== ~exp) begin
      n_bad++;
      $display("FAIL %s/R9 ca: got %h exp %h", req, seg_ca, ~exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    cap = 1'b0; lt_n = 1'b1; bl_n = 1'b1; bcd = 4'd7;
    rst_n = 1'b0;
    step(); #1;
    chk("R10", pat(4'd0));
    rst_n = 1'b1;
    step(); step(); #1;
    chk("R10", pat(4'd0));
  endtask

  task automatic t_digits();
    cap = 1'b1;
    for (int d = 0; d < 10; d++) begin
      step(); bcd = d[3:0]; #1;
      chk(d < 4 ? "R1" : "R2", pat(d[3:0]));
    end
  endtask

  task automatic t_bad_codes();
    cap = 1'b1;
    for (int d = 10; d < 16; d++) begin
      step(); bcd = d[3:0]; #1;
      chk("R3", 7'h00);
    end
  endtask

  task automatic t_follow();
    cap = 1'b1;
    step(); bcd = 4'd4; #1; chk("R4", pat(4'd4));
    #2; bcd = 4'd6; #1; chk("R4", pat(4'd6));
  endtask

  task automatic t_hold();
    cap = 1'b1;
    step(); bcd = 4'd5;
    step(); cap = 1'b0; bcd = 4'd8; #1;
    chk("R5", pat(4'd5));
    step(); bcd = 4'd2;
    step(); #1;
    chk("R5", pat(4'd5));
  endtask

  task automatic t_lamp();
    cap = 1'b1; bcd = 4'd1; lt_n = 1'b0; bl_n = 1'b1;
    step(); #1; chk("R6", 7'h7F);
    bl_n = 1'b0; bcd = 4'd12; #1; chk("R6", 7'h7F);
    lt_n = 1'b1; bl_n = 1'b1;
  endtask

  task automatic t_blank_keeps();
    cap = 1'b1; bcd = 4'd9;
    step(); step(); cap = 1'b0; bcd = 4'd3;
    bl_n = 1'b0; #1;
    chk("R7", 7'h00);
    step(); bcd = 4'd0; step(); #1;
    chk("R7", 7'h00);
    bl_n = 1'b1; #1;
    chk("R8", pat(4'd9));
  endtask

  initial begin
    t_reset();
    t_digits();
    t_bad_codes();
    t_follow();
    t_hold();
    t_lamp();
    t_blank_keeps();
    step();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule